// File: doc/BRIEF.md
# Tiered Power-Up Sequencer

This block runs from the always-on standby domain and brings the board's supply rails up in numbered groups. A power-on request starts the sequence. The block enables group 0 and then waits until every rail in that group reports power-good. Only then does it enable the next group. The final group is held back until a fixed delay has passed since the sequence began. When the final group is good, the block raises power-ok and a drive strobe that allows the reset-sampled configuration values to be driven.

A group that does not report good within the power-good window halts the sequence. In that case the fault flag is set, the enables already given stay on, and the block waits there. Two events trigger power-down: the request being withdrawn, or the over-temperature input being raised. Power-down drops the enables from the highest group to the lowest, one per clock, and then returns the block to idle. An over-temperature shutdown also sets the fault flag. A set fault flag blocks any restart until the request is removed.

Top module: `pwr_tier_seq`

## Requirements
- R1: Groups are enabled in ascending order. `grp_en` bit g drives group g, and its rails are `rail_good[g*RAILS +: RAILS]`. A group below the last is enabled one clock after the first clock edge on which every rail of the previous group is sampled good. The first sample is taken on the edge after that group's enable.
- R2: The enable of the last group rises at the later of two times: two clocks after the group before it is first sampled all-good, or LAST_DELAY_MS*(CLK_HZ/1000)+1 clocks after group 0 is enabled.
- R3: On the clock after every rail of the last group is sampled good, `power_ok` and `cfg_drive` rise and `state_code` reads 3 (on).
- R4: A group that is not sampled all-good within TIMEOUT_MS*(CLK_HZ/1000) clocks of its enable causes a stall at exactly that clock. At that point `fault` is 1 and `state_code` is 4 (stalled). The enables are held and no further group is enabled, even if the rails later become good.
- R5: Dropping `pwr_req` in any active state gives `state_code` 5 (powering down) on the next clock. After that, one enable is cleared per clock, highest group first. The clock after all enables are clear, `state_code` returns to 0 (idle).
- R6: Raising `therm_alarm` in any active state starts the same power-down as R5 and sets `fault` on the same clock. While `therm_alarm` is high, the block does not start from idle.
- R7: After reset, all enables, `power_ok`, `cfg_drive` and `fault` are 0 and `state_code` is 0. While `fault` is set, idle does not restart. `fault` clears in idle once `pwr_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Level request to power the board up |
| therm_alarm | input | 1 | Over-temperature alarm, forces power-down |
| rail_good | input | GROUPS*RAILS | Per-rail power-good, group g in bits g*RAILS and up |
| grp_en | output | GROUPS | Per-group supply enable, bit g for group g |
| power_ok | output | 1 | All groups up and stable |
| cfg_drive | output | 1 | Reset-sampled configuration may be driven |
| fault | output | 1 | Power-good timeout or thermal shutdown occurred |
| state_code | output | 3 | 0 idle, 1 ramping, 2 holding, 3 on, 4 stalled, 5 powering down |

## Verification
The bench builds the block with three groups of two rails, CLK_HZ of 8000, LAST_DELAY_MS of 5 and TIMEOUT_MS of 1. With these values one millisecond is eight clocks. The final-tier hold therefore ends 41 clocks after start, and the power-good window is eight clocks. This keeps the hold, the exact timeout edge (good on the eighth clock passes, on the ninth it stalls) and stalls in each tier within a short run. A dead rail in a middle group, thermal shutdown from the on state, and the restart lockout after a fault are also exercised.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAMP  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_ON    = 3'd3,
    ST_STALL = 3'd4,
    ST_DOWN  = 3'd5
  } seq_state_t;

  // clocks per millisecond, never below one
  function automatic int unsigned cycles_per_ms(input int unsigned clk_hz);
    int unsigned c;
    c = clk_hz / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // register width able to hold the value n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pwr_ms_timer.sv
module pwr_ms_timer
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 100000,
  parameter int unsigned LIMIT_MS   = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic reached
);
  localparam int unsigned PW = bits_for(CYC_PER_MS);
  localparam int unsigned MW = bits_for(LIMIT_MS);

  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic          tick;

  assign tick    = (pre == PW'(CYC_PER_MS - 1));
  assign reached = (ms == MW'(LIMIT_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ms  <= '0;
    end else if (restart) begin
      pre <= '0;
      ms  <= '0;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick && !reached) ms <= ms + MW'(1);
    end
  end

  AST_MS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !restart) |=> reached); // R2

endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer
  import pwr_seq_pkg::*;
#(
  parameter int unsigned TMO_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned TW = bits_for(TMO_CYC);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (!expired) cnt <= cnt + TW'(1);
  end

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired); // R4

endmodule

// File: rtl/pwr_grp_good.sv
module pwr_grp_good #(
  parameter int unsigned GROUPS = 3,
  parameter int unsigned RAILS  = 2
) (
  input  logic [GROUPS*RAILS-1:0] rail_good,
  output logic [GROUPS-1:0]       all_good
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign all_good[g] = &rail_good[g*RAILS +: RAILS];
  end
endmodule

// File: rtl/pwr_tier_seq.sv
module pwr_tier_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned GROUPS        = 3,
  parameter int unsigned RAILS         = 2,
  parameter int unsigned CLK_HZ        = 25000000,
  parameter int unsigned LAST_DELAY_MS = 330,
  parameter int unsigned TIMEOUT_MS    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_req,
  input  logic                    therm_alarm,
  input  logic [GROUPS*RAILS-1:0] rail_good,
  output logic [GROUPS-1:0]       grp_en,
  output logic                    power_ok,
  output logic                    cfg_drive,
  output logic                    fault,
  output logic [2:0]              state_code
);
  localparam int unsigned CYC     = cycles_per_ms(CLK_HZ);
  localparam int unsigned TMO_CYC = TIMEOUT_MS * CYC;
  localparam int unsigned GW      = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [GW-1:0] LAST_IDX = GW'(GROUPS - 1);

  seq_state_t        state;
  logic [GW-1:0]     grp, grp_nxt;
  logic [GROUPS-1:0] grp_ok;
  logic              cur_good, ms_reached, tmo_expired;

  // named events
  logic shutdown_evt, start_evt, advance_evt, timeout_evt, release_evt;
  logic on_evt, hold_evt, step_evt, launch_evt;

  // clear the highest set enable
  function automatic logic [GROUPS-1:0] drop_highest(input logic [GROUPS-1:0] v);
    logic [GROUPS-1:0] r;
    logic              found;
    r     = v;
    found = 1'b0;
    for (int i = GROUPS - 1; i >= 0; i--) begin
      if (v[i] && !found) begin
        r[i]  = 1'b0;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  pwr_grp_good #(.GROUPS(GROUPS), .RAILS(RAILS)) u_good (
    .rail_good (rail_good),
    .all_good  (grp_ok)
  );

  pwr_ms_timer #(.CYC_PER_MS(CYC), .LIMIT_MS(LAST_DELAY_MS)) u_ms (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .reached (ms_reached)
  );

  pwr_step_timer #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch_evt),
    .expired (tmo_expired)
  );

  assign grp_nxt  = grp + GW'(1);
  assign cur_good = grp_ok[grp];

  assign shutdown_evt = (state != ST_IDLE) && (state != ST_DOWN) && (!pwr_req || therm_alarm);
  assign start_evt    = (state == ST_IDLE) && pwr_req && !therm_alarm && !fault;
  assign advance_evt  = (state == ST_RAMP) && !shutdown_evt && cur_good;
  assign timeout_evt  = (state == ST_RAMP) && !shutdown_evt && !cur_good && tmo_expired;
  assign release_evt  = (state == ST_HOLD) && !shutdown_evt && ms_reached;
  assign on_evt       = advance_evt && (grp == LAST_IDX);
  assign hold_evt     = advance_evt && (grp != LAST_IDX) && (grp_nxt == LAST_IDX);
  assign step_evt     = advance_evt && !on_evt && !hold_evt;
  assign launch_evt   = start_evt || step_evt || release_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      grp    <= '0;
      grp_en <= '0;
      fault  <= 1'b0;
    end else if (shutdown_evt) begin
      state <= ST_DOWN;
      if (therm_alarm) fault <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!pwr_req) fault <= 1'b0;
          else if (start_evt) begin
            state  <= ST_RAMP;
            grp    <= '0;
            grp_en <= GROUPS'(1);
          end
        end
        ST_RAMP: begin
          if (on_evt)        state <= ST_ON;
          else if (hold_evt) state <= ST_HOLD;
          else if (step_evt) begin
            grp            <= grp_nxt;
            grp_en[grp_nxt] <= 1'b1;
          end else if (timeout_evt) begin
            fault <= 1'b1;
            state <= ST_STALL;
          end
        end
        ST_HOLD: begin
          if (release_evt) begin
            grp              <= LAST_IDX;
            grp_en[LAST_IDX] <= 1'b1;
            state            <= ST_RAMP;
          end
        end
        ST_DOWN: begin
          if (grp_en == '0) state <= ST_IDLE;
          else              grp_en <= drop_highest(grp_en);
        end
        default: ;
      endcase
    end
  end

  assign power_ok   = (state == ST_ON);
  assign cfg_drive  = (state == ST_ON);
  assign state_code = state;

  for (genvar g = 1; g < GROUPS; g++) begin : g_ord
    AST_ENABLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en[g] |-> grp_en[g-1]); // R1
  end

  AST_LAST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_en[GROUPS-1]) |-> ms_reached); // R2

  AST_ON_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RAMP) && (grp == LAST_IDX) && cur_good && !shutdown_evt) |=> power_ok); // R3

  AST_TIMEOUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (fault && state == ST_STALL)); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STALL) && !shutdown_evt) |=> ((state == ST_STALL) && $stable(grp_en))); // R4

  AST_DOWN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DOWN) && (grp_en != '0)) |=> ($countones(grp_en) + 1 == $countones($past(grp_en)))); // R5

  AST_THERM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_alarm && (state != ST_IDLE) && (state != ST_DOWN)) |=> ((state == ST_DOWN) && fault)); // R6

  AST_NO_START_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && (fault || therm_alarm)) |=> (state == ST_IDLE)); // R7

endmodule

// File: tb/sim_pwr_tier_seq.sv
module sim_pwr_tier_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NG   = 3;
  localparam int NR   = 2;
  localparam int HZ   = 8000;
  localparam int DMS  = 5;
  localparam int TMS  = 1;
  localparam int CPM  = HZ / 1000;
  localparam int TMO  = TMS * CPM;
  localparam int HOLD = DMS * CPM + 1;

  // rows: {bad_group(3 = none), d2, d1, d0}; dn = clocks after enable before rails good
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    32'h03000000, 32'h03070707, 32'h03020503, 32'h03000008,
    32'h03000802, 32'h03080000, 32'h01010101
  };

  logic clk = 0, rst_n = 0, pwr_req = 0, therm_alarm = 0;
  logic [NG*NR-1:0] rail_good = '0;
  logic [NG-1:0] grp_en;
  logic power_ok, cfg_drive, fault;
  logic [2:0] state_code;

  int checks = 0, errors = 0;
  int dly [NG];
  int cnt [NG];
  logic [NG-1:0] bad = '0;
  bit force_good = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_tier_seq #(.GROUPS(NG), .RAILS(NR), .CLK_HZ(HZ), .LAST_DELAY_MS(DMS), .TIMEOUT_MS(TMS)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .therm_alarm(therm_alarm),
    .rail_good(rail_good), .grp_en(grp_en), .power_ok(power_ok), .cfg_drive(cfg_drive),
    .fault(fault), .state_code(state_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one clock; rails model supplies that settle dly[g] clocks after enable
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      cnt[g] = grp_en[g] ? cnt[g] + 1 : 0;
      for (int r = 0; r < NR; r++)
        rail_good[g*NR + r] = force_good || ((cnt[g] > dly[g]) && !(bad[g] && r == 1));
    end
  endtask

  task automatic power_down_check(input logic [NG-1:0] start_mask, input string tag);
    logic [NG-1:0] exp;
    exp = start_mask;
    step();
    chk(state_code == 3'd5, tag, state_code, 5);
    chk(grp_en == exp, tag, grp_en, exp);
    while (exp != '0) begin
      for (int i = NG - 1; i >= 0; i--) if (exp[i]) begin exp[i] = 1'b0; break; end
      step();
      chk(grp_en == exp, tag, grp_en, exp);
    end
    step();
    chk(state_code == 3'd0, tag, state_code, 0);
  endtask

  task automatic run_row(input logic [31:0] v);
    int er [NG];
    int fr [NG];
    int eok, efault, fok, ffault, bidx;
    logic [NG-1:0] emask;
    bidx = int'(v[31:24]);
    for (int g = 0; g < NG; g++) begin
      dly[g] = int'(v[g*8 +: 8]);
      er[g] = -1; fr[g] = -1;
    end
    bad = (bidx < NG) ? NG'(1 << bidx) : '0;
    eok = -1; efault = -1; fok = -1; ffault = -1;
    er[0] = 0;
    for (int g = 0; g < NG; g++) begin
      if (g == bidx || dly[g] >= TMO) begin efault = er[g] + TMO; break; end
      if (g == NG - 1)       eok = er[g] + 1 + dly[g];
      else if (g + 1 == NG - 1) er[g+1] = (er[g] + 2 + dly[g] > HOLD) ? er[g] + 2 + dly[g] : HOLD;
      else                   er[g+1] = er[g] + 1 + dly[g];
    end
    emask = '0;
    for (int g = 0; g < NG; g++) if (er[g] >= 0) emask[g] = 1'b1;

    pwr_req = 1;
    for (int n = 0; n < 80; n++) begin
      step();
      for (int g = 0; g < NG; g++) if (grp_en[g] && fr[g] < 0) fr[g] = n;
      if (power_ok && fok < 0) fok = n;
      if (fault && ffault < 0) ffault = n;
    end
    for (int g = 0; g < NG; g++)
      chk(fr[g] == er[g], (g == NG - 1) ? "R2 last enable time" : "R1 enable time", fr[g], er[g]);
    chk(fok == eok, "R3 power_ok time", fok, eok);
    chk(ffault == efault, "R4 fault time", ffault, efault);
    if (eok >= 0) begin
      chk(state_code == 3'd3 && cfg_drive, "R3 on state", state_code, 3);
    end else begin
      chk(state_code == 3'd4, "R4 stalled state", state_code, 4);
      chk(grp_en == emask, "R4 held enables", grp_en, emask);
    end
    pwr_req = 0;
    power_down_check(emask, "R5 ordered release");
    repeat (3) step();
    chk(fault == 1'b0, "R7 fault cleared in idle", fault, 0);
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin dly[g] = 0; cnt[g] = 0; end
    repeat (3) @(negedge clk);
    pwr_req = 1; therm_alarm = 1;
    rst_n = 1;
    @(negedge clk);
    chk(grp_en == '0, "R7 reset enables", grp_en, 0);
    chk(!power_ok && !cfg_drive, "R7 reset power_ok", power_ok, 0);
    chk(!fault, "R7 reset fault", fault, 0);
    chk(state_code == 3'd0, "R7 reset state", state_code, 0);
    repeat (4) step();
    chk(state_code == 3'd0 && grp_en == '0, "R6 no start while hot", state_code, 0);
    pwr_req = 0; therm_alarm = 0;
    step();

    for (int i = 0; i < NV; i++) run_row(VEC[i]);

    // thermal shutdown from on
    for (int g = 0; g < NG; g++) dly[g] = 0;
    bad = '0;
    pwr_req = 1;
    repeat (HOLD + 4) step();
    chk(state_code == 3'd3, "R3 reached on", state_code, 3);
    therm_alarm = 1;
    step();
    chk(state_code == 3'd5 && fault, "R6 thermal down", state_code, 5);
    chk(grp_en == 3'b111, "R6 enables before release", grp_en, 7);
    for (int k = 0; k < 4; k++) step();
    chk(state_code == 3'd0 && grp_en == '0, "R6 idle after thermal", state_code, 0);
    repeat (4) step();
    chk(state_code == 3'd0, "R6 held idle while hot", state_code, 0);
    therm_alarm = 0;
    repeat (4) step();
    chk(state_code == 3'd0 && fault, "R7 fault blocks restart", state_code, 0);
    pwr_req = 0;
    repeat (2) step();
    chk(!fault, "R7 fault cleared", fault, 0);
    pwr_req = 1;
    step();
    chk(grp_en == 3'b001 && state_code == 3'd1, "R1 restart enables group 0", grp_en, 1);
    pwr_req = 0;
    power_down_check(3'b001, "R5 short release");

    // stall, then rails all good: still stalled
    dly[0] = 20;
    pwr_req = 1;
    repeat (TMO + 1) step();
    chk(state_code == 3'd4 && fault, "R4 stall on slow group", state_code, 4);
    force_good = 1;
    repeat (10) step();
    chk(state_code == 3'd4 && grp_en == 3'b001, "R4 no advance after late good", grp_en, 1);
    force_good = 0;
    pwr_req = 0;
    power_down_check(3'b001, "R5 release from stall");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule